// File: doc/BRIEF.md
# Serial Control Register Slave for an Audio/Video Router

This block is the two-wire serial control port of an audio/video routing device. A host master on an I2C bus writes a bank of nine 8-bit control registers. The block presents all nine registers to the switching logic as one parallel bus. The host can also read back one status byte. That byte packs a 2-bit code for each of three slow-blanking lines, which the block receives from a level detector.

The write and read paths work differently. A write names a register subaddress and then streams data bytes. The pointer moves one register forward after every data byte. A read carries no subaddress and always returns the status byte. A strap pin chooses one of two bus addresses. SCL and SDA are sampled by the system clock, and the block pulls SDA low through an open-drain enable.

Top module: `avsw_ctl_slave`

## Requirements
- R1: With `addr_sel` low the slave acknowledges the 8-bit write address 0x94 and ignores 0x96. With `addr_sel` high it acknowledges 0x96 and ignores 0x94. Any other address gets no acknowledge.
- R2: The read address is the write address with bit 0 set (0x95 or 0x97), and the slave acknowledges it.
- R3: A write consists of the address byte, a subaddress byte and a data byte, each acknowledged. The data byte lands in register k, which appears on `ctl_o[8k+7:8k]` for k from 0 to 8.
- R4: After each data byte the subaddress advances by one, so a stream of bytes starting at subaddress 0 fills registers 0 to 8 in order.
- R5: After reset every register bit is 0 and SDA is not driven.
- R6: A data byte aimed at a subaddress above 0x08 is acknowledged but changes nothing. Once the pointer passes 0x08 it stops advancing and does not wrap to 0.
- R7: The first read byte is {2'b00, line3, line2, line1}: `blank_stat_i[1:0]`, `[3:2]` and `[5:4]` land in bits [1:0], [3:2] and [5:4]. The byte is captured when the address byte is acknowledged, so later changes on `blank_stat_i` do not alter it.
- R8: After the status byte the slave releases SDA, so any further bytes read in the same transfer are 0xFF.
- R9: A START at any point, including inside a byte, returns the receiver to address matching without writing anything. A STOP returns it to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_sel | input | 1 | Strap pin that selects the bus address |
| scl_i | input | 1 | Bus clock as seen on the pin |
| sda_i | input | 1 | Bus data as seen on the pin |
| blank_stat_i | input | 6 | Three 2-bit slow-blanking codes from the level detector |
| sda_oe_o | output | 1 | When high, SDA is pulled low |
| ctl_o | output | 72 | Nine control registers; register k sits on bits 8k+7:8k |

## Verification
The write path is exercised with three kinds of transfer: single-byte writes to scattered subaddresses, a nine-byte burst from subaddress 0, and bursts that start at 0x07 or above 0x08. Together these separate a correct pointer from one that wraps, one that fails to advance, and one that writes out of range.

Addresses are tried with both strap levels. Each strap level gets its own address, the other strap's address and the read form. This catches a swapped or ignored select pin.

Reads use two different status patterns, and the input changes partway through the byte. This shows both the bit placement and the capture point. A second byte read after the master's NACK checks that the slave has let go of SDA.

A repeated START inside a subaddress byte and a STOP inside an address byte show that both bus conditions reset the receiver at any bit.

// File: rtl/avsw_pkg.sv
package avsw_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_RD_BYTE,
    ST_RD_DONE
  } xfer_st_e;

  // Device address match: upper six bits fixed, bit 1 from the strap.
  function automatic logic dev_addr_hit(input logic [7:0] addr_byte,
                                        input logic [6:0] base7,
                                        input logic       sel);
    return addr_byte[7:1] == {base7[6:1], sel};
  endfunction

  // Status byte layout: line1 in [1:0], line2 in [3:2], line3 in [5:4].
  function automatic logic [7:0] pack_status(input logic [5:0] lines);
    return {2'b00, lines[5:4], lines[3:2], lines[1:0]};
  endfunction

  // Pointer step: advance while inside the bank, freeze once beyond it.
  function automatic logic [7:0] next_ptr(input logic [7:0] ptr,
                                          input logic [7:0] last);
    return (ptr <= last) ? ptr + 8'd1 : ptr;
  endfunction

endpackage

// File: rtl/avsw_bus_sync.sv
module avsw_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_s
);

  localparam int NLINES = 2;

  logic [NLINES-1:0] pin_raw;
  logic [NLINES-1:0] pin_now;
  logic [NLINES-1:0] pin_prev;

  assign pin_raw = {sda_i, scl_i};

  genvar g;
  generate
    for (g = 0; g < NLINES; g++) begin : g_line
      logic [STAGES-1:0] pipe;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pipe        <= '1;
          pin_prev[g] <= 1'b1;
        end else begin
          pipe        <= {pipe[STAGES-2:0], pin_raw[g]};
          pin_prev[g] <= pipe[STAGES-1];
        end
      end
      assign pin_now[g] = pipe[STAGES-1];
    end
  endgenerate

  logic scl_now, scl_prev, sda_now, sda_prev;
  assign scl_now  = pin_now[0];
  assign scl_prev = pin_prev[0];
  assign sda_now  = pin_now[1];
  assign sda_prev = pin_prev[1];

  assign scl_rise  = scl_now & ~scl_prev;
  assign scl_fall  = ~scl_now & scl_prev;
  assign start_det = scl_now & scl_prev & sda_prev & ~sda_now;
  assign stop_det  = scl_now & scl_prev & ~sda_prev & sda_now;
  assign sda_s     = sda_now;

  // R9: the two bus conditions are never reported together
  a_r9_cond_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_det && stop_det));

  // R9: no clock edge is reported while a bus condition is seen
  a_r9_cond_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |-> !(scl_rise || scl_fall));

endmodule

// File: rtl/avsw_xfer.sv
module avsw_xfer
  import avsw_pkg::*;
#(
  parameter int       NUM_REGS  = 9,
  parameter int       IDX_W     = 4,
  parameter int       STAT_W    = 6,
  parameter bit [6:0] BASE_ADDR = 7'h4A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_sel,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic [STAT_W-1:0] blank_stat,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [7:0]        wr_data,
  output logic              sda_oe
);

  localparam logic [7:0] LAST_SUB = 8'(NUM_REGS - 1);

  xfer_st_e   state;
  logic [2:0] bit_cnt;
  logic [7:0] rx_sh;
  logic [7:0] tx_sh;
  logic [7:0] ptr;
  logic       byte_done;
  logic       rd_req;

  // Named internal events
  logic byte_end;
  logic addr_hit;
  logic in_rx;
  logic in_ack;

  assign byte_end = scl_fall & byte_done;
  assign addr_hit = dev_addr_hit(rx_sh, BASE_ADDR, addr_sel);
  assign in_rx    = (state == ST_ADDR) || (state == ST_SUB) || (state == ST_DATA);
  assign in_ack   = (state == ST_ADDR_ACK) || (state == ST_SUB_ACK) || (state == ST_DATA_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= 8'hFF;
      ptr       <= '0;
      byte_done <= 1'b0;
      rd_req    <= 1'b0;
    end else if (start_det) begin
      state     <= ST_ADDR;
      bit_cnt   <= '0;
      byte_done <= 1'b0;
    end else if (stop_det) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      byte_done <= 1'b0;
    end else begin
      if (in_rx) begin
        if (scl_rise && !byte_done) begin
          rx_sh <= {rx_sh[6:0], sda_s};
          if (bit_cnt == 3'd7) begin
            bit_cnt   <= '0;
            byte_done <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 3'd1;
          end
        end else if (byte_end) begin
          byte_done <= 1'b0;
          unique case (state)
            ST_ADDR: begin
              if (addr_hit) begin
                state  <= ST_ADDR_ACK;
                rd_req <= rx_sh[0];
                if (rx_sh[0]) tx_sh <= pack_status(blank_stat);
              end else begin
                state <= ST_IDLE;
              end
            end
            ST_SUB: begin
              ptr   <= rx_sh;
              state <= ST_SUB_ACK;
            end
            default: begin
              ptr   <= next_ptr(ptr, LAST_SUB);
              state <= ST_DATA_ACK;
            end
          endcase
        end
      end else if (in_ack) begin
        if (scl_fall) begin
          bit_cnt <= '0;
          if (state == ST_ADDR_ACK) state <= rd_req ? ST_RD_BYTE : ST_SUB;
          else                      state <= ST_DATA;
        end
      end else if (state == ST_RD_BYTE) begin
        if (scl_fall) begin
          tx_sh <= {tx_sh[6:0], 1'b1};
          if (bit_cnt == 3'd7) begin
            bit_cnt <= '0;
            state   <= ST_RD_DONE;
          end else begin
            bit_cnt <= bit_cnt + 3'd1;
          end
        end
      end
    end
  end

  assign wr_en   = (state == ST_DATA) && byte_end && !start_det && !stop_det
                   && (ptr <= LAST_SUB);
  assign wr_idx  = ptr[IDX_W-1:0];
  assign wr_data = rx_sh;
  assign sda_oe  = in_ack || ((state == ST_RD_BYTE) && !tx_sh[7]);

  // R9: a START always lands in address matching
  a_r9_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_ADDR));

  // R9: a STOP returns to idle
  a_r9_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !start_det) |=> (state == ST_IDLE));

  // R8: after the status byte the line is released
  a_r8_done_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RD_DONE) |-> !sda_oe);

  // R7: the captured status only moves on a bus clock fall
  a_r7_tx_held: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_RD_BYTE) && !scl_fall && !start_det && !stop_det) |=> $stable(tx_sh));

  // R1: an acknowledge phase is entered only from a matched address byte
  a_r1_ack_after_match: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR && byte_end && !addr_hit && !start_det && !stop_det)
      |=> (state == ST_IDLE));

  // R6: a pointer beyond the bank never moves on a data byte
  a_r6_ptr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_DATA) && (ptr > LAST_SUB) && !start_det && !stop_det) |=> $stable(ptr));

endmodule

// File: rtl/avsw_regbank.sv
module avsw_regbank #(
  parameter int NUM_REGS = 9,
  parameter int IDX_W    = 4,
  parameter int REG_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [REG_W-1:0]          wr_data,
  output logic [NUM_REGS*REG_W-1:0] ctl_o
);

  genvar k;
  generate
    for (k = 0; k < NUM_REGS; k++) begin : g_reg
      logic [REG_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 q <= '0;
        else if (wr_en && (wr_idx == IDX_W'(k)))    q <= wr_data;
      end
      assign ctl_o[k*REG_W +: REG_W] = q;
    end
  endgenerate

  // R5: reset clears every register bit
  a_r5_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (ctl_o == '0));

  // R3: the bank only changes on a write
  a_r3_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !wr_en) |=> $stable(ctl_o));

endmodule

// File: rtl/avsw_ctl_slave.sv
module avsw_ctl_slave
  import avsw_pkg::*;
#(
  parameter int       NUM_REGS    = 9,
  parameter int       SYNC_STAGES = 2,
  parameter int       STAT_W      = 6,
  parameter bit [6:0] BASE_ADDR   = 7'h4A
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   addr_sel,
  input  logic                   scl_i,
  input  logic                   sda_i,
  input  logic [STAT_W-1:0]      blank_stat_i,
  output logic                   sda_oe_o,
  output logic [NUM_REGS*8-1:0]  ctl_o
);

  localparam int IDX_W = $clog2(NUM_REGS);

  logic scl_rise, scl_fall, start_det, stop_det, sda_s;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_data;

  avsw_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_s     (sda_s)
  );

  avsw_xfer #(
    .NUM_REGS  (NUM_REGS),
    .IDX_W     (IDX_W),
    .STAT_W    (STAT_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_xfer (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_sel   (addr_sel),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .sda_s      (sda_s),
    .blank_stat (blank_stat_i),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .sda_oe     (sda_oe_o)
  );

  avsw_regbank #(
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W),
    .REG_W    (8)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .ctl_o   (ctl_o)
  );

  // R3: a write is only issued for an index inside the bank
  a_r3_write_in_bank: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_idx) < NUM_REGS));

endmodule

// File: tb/avsw_ctl_slave_test.sv
module avsw_ctl_slave_test;

  localparam int NREG = 9;
  localparam int H    = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_sel = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [5:0] blank = 6'd0;
  logic sda_oe;
  logic [NREG*8-1:0] ctl;
  logic sda_line;

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  avsw_ctl_slave uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_sel     (addr_sel),
    .scl_i        (scl_m),
    .sda_i        (sda_line),
    .blank_stat_i (blank),
    .sda_oe_o     (sda_oe),
    .ctl_o        (ctl)
  );

  int n_run = 0;
  int n_fail = 0;
  int mism = 0;
  bit quiet = 1'b0;
  int exp_regs[NREG];
  logic [7:0] wdat[16];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Reference model compare, every clock while the bus is quiet
  always @(negedge clk) begin
    if (quiet && rst_n) begin
      for (int k = 0; k < NREG; k++)
        if (ctl[k*8 +: 8] != exp_regs[k][7:0]) mism++;
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold(H);
    scl_m = 1'b1; hold(H);
    sda_m = 1'b0; hold(H);
    scl_m = 1'b0; hold(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(H);
    scl_m = 1'b1; hold(H);
    sda_m = 1'b1; hold(H);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; hold(H);
    scl_m = 1'b1; hold(H);
    scl_m = 1'b0; hold(H);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; hold(H);
    scl_m = 1'b1; hold(H/2);
    b = sda_line; hold(H - H/2);
    scl_m = 1'b0; hold(H);
  endtask

  task automatic put_byte(input logic [7:0] v, output bit ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    ack = (a == 1'b0);
  endtask

  task automatic get_byte(output logic [7:0] v, input logic master_nack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(master_nack);
  endtask

  function automatic bit model_hit(input logic [7:0] dev);
    return (dev[7:1] == 7'h4A && !addr_sel) || (dev[7:1] == 7'h4B && addr_sel);
  endfunction

  // Write transfer with n data bytes from wdat; model updated behaviourally
  task automatic wr_txn(input logic [7:0] dev, input logic [7:0] sub, input int n, input string req);
    bit ack;
    bit hit;
    int p;
    quiet = 1'b0;
    hit = model_hit(dev);
    bus_start();
    put_byte(dev, ack);
    chk(ack == hit, {req, " address acknowledge"}, 32'(ack), 32'(hit));
    if (hit) begin
      put_byte(sub, ack);
      chk(ack, {req, " subaddress acknowledge"}, 32'(ack), 1);
      p = int'(sub);
      for (int i = 0; i < n; i++) begin
        put_byte(wdat[i], ack);
        chk(ack, {req, " data acknowledge"}, 32'(ack), 1);
        if (p < NREG) begin
          exp_regs[p] = int'(wdat[i]);
          p++;
        end
      end
    end
    bus_stop();
    hold(8);
    quiet = 1'b1;
  endtask

  function automatic logic [7:0] reg_at(input int k);
    return ctl[k*8 +: 8];
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    bit ack;
    logic [7:0] rb;
    for (int k = 0; k < NREG; k++) exp_regs[k] = 0;
    hold(5);
    // R5 reset state
    chk(ctl == '0, "R5 registers cleared in reset", 32'(ctl[31:0]), 0);
    chk(sda_oe == 1'b0, "R5 SDA released in reset", 32'(sda_oe), 0);
    rst_n = 1'b1;
    hold(5);
    quiet = 1'b1;
    chk(ctl == '0, "R5 registers cleared after reset", 32'(ctl[31:0]), 0);

    // R1, R3: single write with strap low
    wdat[0] = 8'hA5;
    wr_txn(8'h94, 8'h02, 1, "R1 R3 sel0 0x94");
    chk(reg_at(2) == 8'hA5, "R3 register 2 written", 32'(reg_at(2)), 32'hA5);

    // R1: other strap address ignored
    wdat[0] = 8'h66;
    wr_txn(8'h96, 8'h02, 1, "R1 sel0 0x96 ignored");
    chk(reg_at(2) == 8'hA5, "R1 register 2 untouched", 32'(reg_at(2)), 32'hA5);

    // R4: nine-byte burst from 0
    for (int i = 0; i < NREG; i++) wdat[i] = 8'h10 + 8'(i);
    wr_txn(8'h94, 8'h00, NREG, "R4 burst");
    chk(reg_at(0) == 8'h10, "R4 first register", 32'(reg_at(0)), 32'h10);
    chk(reg_at(8) == 8'h18, "R4 last register", 32'(reg_at(8)), 32'h18);

    // R6: burst across the end of the bank
    wdat[0] = 8'h3C; wdat[1] = 8'h81; wdat[2] = 8'h77; wdat[3] = 8'h5A;
    wr_txn(8'h94, 8'h07, 4, "R6 overrun");
    chk(reg_at(7) == 8'h3C, "R6 register 7", 32'(reg_at(7)), 32'h3C);
    chk(reg_at(8) == 8'h81, "R6 register 8", 32'(reg_at(8)), 32'h81);
    chk(reg_at(0) == 8'h10, "R6 no wrap to register 0", 32'(reg_at(0)), 32'h10);

    // R6: subaddress above the bank
    wdat[0] = 8'h55; wdat[1] = 8'hAA;
    wr_txn(8'h94, 8'h0C, 2, "R6 high subaddress");
    chk(ctl[71:64] == 8'h81 && reg_at(0) == 8'h10, "R6 high subaddress discarded",
        32'(reg_at(0)), 32'h10);

    // R1: strap high
    addr_sel = 1'b1;
    hold(4);
    wdat[0] = 8'h99;
    wr_txn(8'h94, 8'h01, 1, "R1 sel1 0x94 ignored");
    wr_txn(8'h96, 8'h01, 1, "R1 sel1 0x96");
    chk(reg_at(1) == 8'h99, "R1 register 1 via 0x96", 32'(reg_at(1)), 32'h99);
    wdat[0] = 8'h24;
    wr_txn(8'h98, 8'h01, 1, "R1 foreign address");

    // R2, R7, R8: read with capture
    quiet = 1'b0;
    blank = 6'b11_10_01;
    hold(4);
    bus_start();
    put_byte(8'h97, ack);
    chk(ack, "R2 read address acknowledged", 32'(ack), 1);
    blank = 6'b01_01_01;
    get_byte(rb, 1'b1);
    chk(rb == 8'h39, "R7 status byte captured at address", 32'(rb), 32'h39);
    get_byte(rb, 1'b1);
    chk(rb == 8'hFF, "R8 byte after status", 32'(rb), 32'hFF);
    bus_stop();
    bus_start();
    put_byte(8'h97, ack);
    get_byte(rb, 1'b1);
    chk(rb == 8'h15, "R7 second status pattern", 32'(rb), 32'h15);
    bus_stop();

    // R9: repeated START inside a subaddress byte
    bus_start();
    put_byte(8'h96, ack);
    put_bit(1'b0); put_bit(1'b0); put_bit(1'b1);
    blank = 6'b10_11_00;
    bus_start();
    put_byte(8'h97, ack);
    chk(ack, "R9 restart reaches address matching", 32'(ack), 1);
    get_byte(rb, 1'b1);
    chk(rb == 8'h2C, "R9 read after restart", 32'(rb), 32'h2C);
    bus_stop();
    hold(8);
    quiet = 1'b1;

    // R9: STOP inside an address byte
    quiet = 1'b0;
    bus_start();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b0); put_bit(1'b1);
    bus_stop();
    hold(8);
    quiet = 1'b1;
    chk(sda_oe == 1'b0, "R9 idle after stop", 32'(sda_oe), 0);
    wdat[0] = 8'h42;
    wr_txn(8'h96, 8'h04, 1, "R9 write after stop");
    chk(reg_at(4) == 8'h42, "R9 register 4 after stop", 32'(reg_at(4)), 32'h42);

    chk(mism == 0, "R3 continuous model compare", 32'(mism), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule